// File: doc/BRIEF.md
# Supply and Sensor Limit Monitor Core

This block is the digital heart of a system health monitor. A converter outside the block hands it 10-bit measurement results, one per cycle at most. Each result carries a channel number: channels 0 to 5 are supply voltages, two of which are processor core rails, and channel 6 is temperature. Each result lands in that channel's value register and is compared at once against the channel's programmable upper and lower bounds. A result outside the bounds latches a sticky status bit. The status bits are qualified by a mask and a global enable, and the result drives a single interrupt line.

The core also measures the rotation period of two fans. It counts ticks of a reference strobe between rising edges of each tachometer signal. A cover-intrusion input is latched as a status bit. A command bit produces an active-low pulse that clears the external intrusion latch. Five processor voltage-identification pins are synchronised and can be read back. A simple synchronous register port gives the host access to everything: a write strobe, a read strobe, an address and combinational read data.

Top module: `hwmon_limit_core`

## Requirements
- R1: A cycle with `res_valid` high and `res_chan` = c (c from 0 to 6) stores `res_data` into value register c, which reads at address 0x00+c from the next cycle. A result tagged with channel 7 changes no value register and no status bit.
- R2: The upper bound of channel c is read and written at 0x08+c, and its lower bound at 0x10+c. Both are 10 bits wide. After reset the upper bound reads 0x3FF and the lower bound reads 0x000.
- R3: A result for channel c sets status bit c (register 0x18) on the same clock edge that stores it, when the result is strictly above the upper bound or strictly below the lower bound. A result equal to either bound is in range and sets nothing.
- R4: A status bit that is set stays set until the host reads 0x18, which clears every bit, or writes 0x18 with a 1 in that bit position. Bits written with 0 are kept. If a clear and a new out-of-range event reach the same bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when configuration bit 0 (register 0x1A) is 1 and at least one status bit is set whose bit in the mask register 0x19 is also 1.
- R6: Fan f (0 or 1) reports at 0x1B+f the number of `ref_tick` cycles between its last two rising tachometer edges. When no edge arrives, the count stops at 0xFF, and the register shows 0xFF once the count reaches that value.
- R7: A high level on `intr_in`, after synchronisation, sets status bit 7. The bit stays set after the input returns low, under the same clearing rules as R4.
- R8: Writing 1 to configuration bit 1 drives `intr_clr_n` low for exactly CLR_PULSE cycles (4 by default), starting the cycle after the write. Bit 1 always reads back as 0.
- R9: The synchronised state of `vid_in` reads in bits 4:0 of 0x1D.
- R10: After reset the status, mask and configuration registers read 0, `irq` is low and `intr_clr_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | A measurement result is presented this cycle |
| res_chan | input | 3 | Channel tag of the result (0..6 valid) |
| res_data | input | 10 | Measurement result |
| fan_tach | input | 2 | Tachometer signals, one per fan, asynchronous |
| ref_tick | input | 1 | Reference strobe counted for fan periods |
| intr_in | input | 1 | Level from the external intrusion latch, asynchronous |
| intr_clr_n | output | 1 | Active-low clear pulse to the external intrusion latch |
| vid_in | input | 5 | Processor voltage-identification pins, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read of 0x18 clears status) |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a status clear and a new out-of-range event landing in the same cycle. Only that collision shows whether setting a bit wins over clearing it. The bench drives a write-one-to-clear and an out-of-range result on the same falling edge, then reads the status back. The stalled-fan case is also hard to reach. Because `ref_tick` toggles every cycle, the bench has to hold a tachometer still for over 510 cycles before saturation shows. The comparison is swept over every 10-bit value on all seven channels, each channel with its own bounds, so every bound-equal value is hit.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;

   localparam int BUS_W      = 16;
   localparam int ADDR_W     = 6;
   localparam int CHAN_SLOTS = 8;

   // address map: channel windows are CHAN_SLOTS wide
   localparam logic [ADDR_W-1:0] A_VAL  = 6'h00;
   localparam logic [ADDR_W-1:0] A_HI   = 6'h08;
   localparam logic [ADDR_W-1:0] A_LO   = 6'h10;
   localparam logic [ADDR_W-1:0] A_STAT = 6'h18;
   localparam logic [ADDR_W-1:0] A_MASK = 6'h19;
   localparam logic [ADDR_W-1:0] A_CFG  = 6'h1A;
   localparam logic [ADDR_W-1:0] A_FAN  = 6'h1B;
   localparam logic [ADDR_W-1:0] A_VID  = 6'h1D;

   localparam int CFG_IRQ_EN = 0;
   localparam int CFG_ICLR   = 1;

   typedef struct packed {
      logic              wr;
      logic              rd;
      logic [ADDR_W-1:0] addr;
      logic [BUS_W-1:0]  wdata;
   } bus_req_t;

endpackage

// File: rtl/hwmon_sync.sv
module hwmon_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("hwmon_sync: W must be at least 1");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
            end else begin
               pipe[0] <= d;
               for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/hwmon_chan_bank.sv
module hwmon_chan_bank
   import hwmon_pkg::*;
#(
   parameter int N_CH   = 7,
   parameter int DATA_W = 10,
   parameter int CH_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     res_valid,
   input  logic [CH_W-1:0]          res_chan,
   input  logic [DATA_W-1:0]        res_data,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [N_CH*DATA_W-1:0]   val_flat,
   output logic [N_CH*DATA_W-1:0]   hi_flat,
   output logic [N_CH*DATA_W-1:0]   lo_flat,
   output logic [N_CH-1:0]          oor_hit
);

   if (N_CH > (1 << CH_W)) begin : g_bad_tag
      $error("hwmon_chan_bank: channel tag too narrow for N_CH");
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      logic [DATA_W-1:0] val_q, hi_q, lo_q;
      logic              sel_res, sel_hi, sel_lo;

      assign sel_res = res_valid && (res_chan == CH_W'(i));
      assign sel_hi  = wr_en && (wr_addr == ADDR_W'(A_HI + i));
      assign sel_lo  = wr_en && (wr_addr == ADDR_W'(A_LO + i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
            hi_q  <= '1;
            lo_q  <= '0;
         end else begin
            if (sel_res) val_q <= res_data;
            if (sel_hi)  hi_q  <= wr_data;
            if (sel_lo)  lo_q  <= wr_data;
         end
      end

      // bound-equal values count as in range
      assign oor_hit[i] = sel_res && ((res_data > hi_q) || (res_data < lo_q));

      assign val_flat[i*DATA_W +: DATA_W] = val_q;
      assign hi_flat[i*DATA_W +: DATA_W]  = hi_q;
      assign lo_flat[i*DATA_W +: DATA_W]  = lo_q;
   end

endmodule

// File: rtl/hwmon_fan_counter.sv
module hwmon_fan_counter #(
   parameter int CNT_W = 8,
   parameter int SYNC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tach,
   input  logic             ref_tick,
   output logic [CNT_W-1:0] period
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             tach_s, tach_d, edge_hit;
   logic [CNT_W-1:0] cnt_q, cnt_inc;

   hwmon_sync #(.W(1), .STAGES(SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (tach),
      .q     (tach_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tach_d <= 1'b0;
      else        tach_d <= tach_s;
   end

   assign edge_hit = tach_s & ~tach_d;
   assign cnt_inc  = (ref_tick && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         period <= '0;
      end else if (edge_hit) begin
         period <= cnt_inc;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_inc;
         if (cnt_inc == CNT_MAX) period <= CNT_MAX;
      end
   end

endmodule

// File: rtl/hwmon_intrusion.sv
module hwmon_intrusion #(
   parameter int SYNC  = 2,
   parameter int PULSE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic intr_raw,
   input  logic clr_req,
   output logic intr_seen,
   output logic intr_clr_n
);

   localparam int PW = $clog2(PULSE + 1);

   logic [PW-1:0] left_q;

   hwmon_sync #(.W(1), .STAGES(SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (intr_raw),
      .q     (intr_seen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (clr_req)        left_q <= PW'(PULSE);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign intr_clr_n = (left_q == '0);

endmodule

// File: rtl/hwmon_limit_core.sv
module hwmon_limit_core
   import hwmon_pkg::*;
#(
   parameter  int N_CH        = 7,
   parameter  int DATA_W      = 10,
   parameter  int FAN_N       = 2,
   parameter  int FAN_W       = 8,
   parameter  int VID_W       = 5,
   parameter  int SYNC_STAGES = 2,
   parameter  int CLR_PULSE   = 4,
   localparam int CH_W        = $clog2(CHAN_SLOTS),
   localparam int STAT_W      = N_CH + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               res_valid,
   input  logic [CH_W-1:0]    res_chan,
   input  logic [DATA_W-1:0]  res_data,
   input  logic [FAN_N-1:0]   fan_tach,
   input  logic               ref_tick,
   input  logic               intr_in,
   output logic               intr_clr_n,
   input  logic [VID_W-1:0]   vid_in,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [BUS_W-1:0]   reg_wdata,
   output logic [BUS_W-1:0]   reg_rdata,
   output logic               irq
);

   // elaboration-time parameter checks
   if (N_CH < 1 || N_CH > CHAN_SLOTS - 1) begin : g_bad_nch
      $error("hwmon_limit_core: N_CH must lie in 1..%0d", CHAN_SLOTS - 1);
   end
   if (DATA_W < 1 || DATA_W > BUS_W) begin : g_bad_data
      $error("hwmon_limit_core: DATA_W must fit the register bus");
   end
   if (FAN_N < 1 || FAN_N > int'(A_VID - A_FAN)) begin : g_bad_fan
      $error("hwmon_limit_core: FAN_N exceeds the fan address window");
   end
   if (FAN_W < 1 || FAN_W > BUS_W || VID_W < 1 || VID_W > BUS_W) begin : g_bad_w
      $error("hwmon_limit_core: fan or VID width does not fit the bus");
   end
   if (CLR_PULSE < 1) begin : g_bad_pulse
      $error("hwmon_limit_core: CLR_PULSE must be at least 1");
   end

   bus_req_t req;
   assign req = '{wr: reg_wr, rd: reg_rd, addr: reg_addr, wdata: reg_wdata};

   logic unused_wdata;
   assign unused_wdata = ^req.wdata;

   // channel values, bounds and comparison
   logic [N_CH*DATA_W-1:0] val_flat, hi_flat, lo_flat;
   logic [N_CH-1:0]        oor_hit;

   hwmon_chan_bank #(.N_CH(N_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .res_chan  (res_chan),
      .res_data  (res_data),
      .wr_en     (req.wr),
      .wr_addr   (req.addr),
      .wr_data   (req.wdata[DATA_W-1:0]),
      .val_flat  (val_flat),
      .hi_flat   (hi_flat),
      .lo_flat   (lo_flat),
      .oor_hit   (oor_hit)
   );

   // fan period counters
   logic [FAN_N*FAN_W-1:0] fan_flat;

   for (genvar f = 0; f < FAN_N; f++) begin : g_fan
      hwmon_fan_counter #(.CNT_W(FAN_W), .SYNC(SYNC_STAGES)) u_fan (
         .clk      (clk),
         .rst_n    (rst_n),
         .tach     (fan_tach[f]),
         .ref_tick (ref_tick),
         .period   (fan_flat[f*FAN_W +: FAN_W])
      );
   end

   // intrusion latch and clear pulse
   logic intr_seen, iclr_req;

   assign iclr_req = req.wr && (req.addr == A_CFG) && req.wdata[CFG_ICLR];

   hwmon_intrusion #(.SYNC(SYNC_STAGES), .PULSE(CLR_PULSE)) u_intr (
      .clk        (clk),
      .rst_n      (rst_n),
      .intr_raw   (intr_in),
      .clr_req    (iclr_req),
      .intr_seen  (intr_seen),
      .intr_clr_n (intr_clr_n)
   );

   // voltage-ID capture
   logic [VID_W-1:0] vid_s;

   hwmon_sync #(.W(VID_W), .STAGES(SYNC_STAGES)) u_vid (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (vid_in),
      .q     (vid_s)
   );

   // sticky status, mask, configuration
   logic [STAT_W-1:0] stat_q, mask_q, stat_set, stat_clr;
   logic              cfg_en_q, stat_hit;

   assign stat_hit = (req.addr == A_STAT);
   assign stat_set = {intr_seen, oor_hit};

   always_comb begin
      stat_clr = '0;
      if (req.rd && stat_hit)      stat_clr = '1;
      else if (req.wr && stat_hit) stat_clr = req.wdata[STAT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q   <= '0;
         mask_q   <= '0;
         cfg_en_q <= 1'b0;
      end else begin
         stat_q <= (stat_q & ~stat_clr) | stat_set;
         if (req.wr && req.addr == A_MASK) mask_q   <= req.wdata[STAT_W-1:0];
         if (req.wr && req.addr == A_CFG)  cfg_en_q <= req.wdata[CFG_IRQ_EN];
      end
   end

   assign irq = cfg_en_q && |(stat_q & mask_q);

   // read data
   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (req.addr == ADDR_W'(A_VAL + i)) reg_rdata[DATA_W-1:0] = val_flat[i*DATA_W +: DATA_W];
         if (req.addr == ADDR_W'(A_HI + i))  reg_rdata[DATA_W-1:0] = hi_flat[i*DATA_W +: DATA_W];
         if (req.addr == ADDR_W'(A_LO + i))  reg_rdata[DATA_W-1:0] = lo_flat[i*DATA_W +: DATA_W];
      end
      for (int f = 0; f < FAN_N; f++) begin
         if (req.addr == ADDR_W'(A_FAN + f)) reg_rdata[FAN_W-1:0] = fan_flat[f*FAN_W +: FAN_W];
      end
      case (req.addr)
         A_STAT:  reg_rdata[STAT_W-1:0] = stat_q;
         A_MASK:  reg_rdata[STAT_W-1:0] = mask_q;
         A_CFG:   reg_rdata[CFG_IRQ_EN] = cfg_en_q;
         A_VID:   reg_rdata[VID_W-1:0]  = vid_s;
         default: ;
      endcase
   end

endmodule

// File: rtl/hwmon_limit_core_chk.sv
module hwmon_limit_core_chk
   import hwmon_pkg::*;
#(
   parameter int N_CH      = 7,
   parameter int DATA_W    = 10,
   parameter int CH_W      = 3,
   parameter int CLR_PULSE = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   res_valid,
   input logic [CH_W-1:0]        res_chan,
   input logic [DATA_W-1:0]      res_data,
   input logic                   reg_wr,
   input logic                   reg_rd,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic [BUS_W-1:0]       reg_wdata,
   input logic [N_CH*DATA_W-1:0] val_flat,
   input logic [N_CH*DATA_W-1:0] hi_flat,
   input logic [N_CH*DATA_W-1:0] lo_flat,
   input logic [N_CH:0]          stat_q,
   input logic                   irq,
   input logic                   intr_clr_n
);

   logic stat_clr_evt, iclr_wr;
   int   low_run;

   assign stat_clr_evt = (reg_rd || reg_wr) && (reg_addr == A_STAT);
   assign iclr_wr      = reg_wr && (reg_addr == A_CFG) && reg_wdata[CFG_ICLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           low_run <= 0;
      else if (iclr_wr)     low_run <= 0;
      else if (!intr_clr_n) low_run <= low_run + 1;
      else                  low_run <= 0;
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_chan
      // R1
      value_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && res_chan == CH_W'(i)) |=> (val_flat[i*DATA_W +: DATA_W] == $past(res_data)));
      // R3
      limit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && res_chan == CH_W'(i) &&
          ((res_data > hi_flat[i*DATA_W +: DATA_W]) || (res_data < lo_flat[i*DATA_W +: DATA_W])))
         |=> stat_q[i]);
      // R3
      in_range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && res_chan == CH_W'(i) && !stat_q[i] &&
          (res_data <= hi_flat[i*DATA_W +: DATA_W]) && (res_data >= lo_flat[i*DATA_W +: DATA_W]))
         |=> !stat_q[i]);
   end

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr_evt |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R5
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !stat_clr_evt && !reg_wr) |=> irq);

   // R8
   clr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(intr_clr_n) |-> $past(iclr_wr));

   // R8
   clr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !intr_clr_n |-> (low_run < CLR_PULSE));

endmodule

bind hwmon_limit_core hwmon_limit_core_chk #(
   .N_CH(N_CH), .DATA_W(DATA_W), .CH_W(CH_W), .CLR_PULSE(CLR_PULSE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .res_valid  (res_valid),
   .res_chan   (res_chan),
   .res_data   (res_data),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .val_flat   (val_flat),
   .hi_flat    (hi_flat),
   .lo_flat    (lo_flat),
   .stat_q     (stat_q),
   .irq        (irq),
   .intr_clr_n (intr_clr_n)
);

// File: tb/test_hwmon_limit_core.sv
module test_hwmon_limit_core;
   import hwmon_pkg::*;

   localparam int N_CH      = 7;
   localparam int CLR_PULSE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [2:0]  res_chan = '0;
   logic [9:0]  res_data = '0;
   logic        tach0 = 1'b0, tach1 = 1'b0;
   logic [1:0]  fan_tach;
   logic        ref_tick = 1'b0;
   logic        intr_in = 1'b0;
   logic        intr_clr_n;
   logic [4:0]  vid_in = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int fan_per0 = 0, fan_per1 = 0;
   int low_cnt = 0;

   always #4 clk = ~clk;

   assign fan_tach = {tach1, tach0};

   hwmon_limit_core i_hwmon_limit_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .res_valid  (res_valid),
      .res_chan   (res_chan),
      .res_data   (res_data),
      .fan_tach   (fan_tach),
      .ref_tick   (ref_tick),
      .intr_in    (intr_in),
      .intr_clr_n (intr_clr_n),
      .vid_in     (vid_in),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .irq        (irq)
   );

   // reference strobe: high every other cycle
   always @(negedge clk) ref_tick <= ~ref_tick;

   always begin
      if (fan_per0 == 0) @(negedge clk);
      else begin
         repeat (fan_per0 / 2) @(negedge clk);
         tach0 = ~tach0;
      end
   end

   always begin
      if (fan_per1 == 0) @(negedge clk);
      else begin
         repeat (fan_per1 / 2) @(negedge clk);
         tach1 = ~tach1;
      end
   end

   always @(negedge clk) if (!intr_clr_n) low_cnt <= low_cnt + 1;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic read_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
      logic [15:0] d;
      bus_read(a, d);
      check(tag, 32'(d), exp);
   endtask

   task automatic push(input int ch, input int v);
      @(negedge clk);
      res_valid = 1'b1; res_chan = ch[2:0]; res_data = v[9:0];
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   function automatic int lo_of(input int ch);
      return 100 + 40 * ch;
   endfunction

   function automatic int hi_of(input int ch);
      return lo_of(ch) + 500 + 10 * ch;
   endfunction

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      @(negedge clk);
      check("R10 irq after reset", 32'(irq), 32'd0);
      check("R10 intr_clr_n after reset", 32'(intr_clr_n), 32'd1);
      read_check("R10 status after reset", A_STAT, 32'd0);
      read_check("R10 mask after reset", A_MASK, 32'd0);
      read_check("R10 config after reset", A_CFG, 32'd0);
      read_check("R2 upper bound reset", A_HI, 32'h3FF);
      read_check("R2 lower bound reset", A_LO, 32'h000);

      fan_per0 = 40;
      fan_per1 = 100;

      // R2 bound write and read back
      for (int ch = 0; ch < N_CH; ch++) begin
         bus_write(6'(A_HI + ch), 16'(hi_of(ch)));
         bus_write(6'(A_LO + ch), 16'(lo_of(ch)));
      end
      for (int ch = 0; ch < N_CH; ch++) begin
         read_check("R2 upper bound", 6'(A_HI + ch), 32'(hi_of(ch)));
         read_check("R2 lower bound", 6'(A_LO + ch), 32'(lo_of(ch)));
      end

      // R1 / R3 full sweep of every value on every channel
      for (int ch = 0; ch < N_CH; ch++) begin
         for (int v = 0; v < 1024; v++) begin
            logic [31:0] exp_st;
            exp_st = ((v > hi_of(ch)) || (v < lo_of(ch))) ? (32'd1 << ch) : 32'd0;
            push(ch, v);
            read_check("R1 stored value", 6'(A_VAL + ch), 32'(v));
            read_check("R3 limit compare", A_STAT, exp_st);
         end
      end
      check("R5 irq quiet with mask clear", 32'(irq), 32'd0);

      // R1 channel tag 7 ignored
      push(7, 5);
      read_check("R1 tag 7 sets no status", A_STAT, 32'd0);
      for (int ch = 0; ch < N_CH; ch++)
         read_check("R1 tag 7 leaves values", 6'(A_VAL + ch), 32'd1023);

      // R4 sticky behaviour
      push(2, 800);
      push(2, 400);
      read_check("R4 held after in-range result", A_STAT, 32'h04);
      read_check("R4 cleared by read", A_STAT, 32'h00);
      push(2, 800);
      bus_write(A_STAT, 16'h0001);
      read_check("R4 zero bits kept on write", A_STAT, 32'h04);
      push(2, 800);
      bus_write(A_STAT, 16'h0004);
      read_check("R4 write-one clears", A_STAT, 32'h00);
      push(2, 800);
      read_check("R4 sets again after clear", A_STAT, 32'h04);
      // clear and new event in the same cycle
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 16'h0004;
      res_valid = 1'b1; res_chan = 3'd2; res_data = 10'd800;
      @(negedge clk);
      reg_wr = 1'b0; res_valid = 1'b0;
      read_check("R4 set wins over clear", A_STAT, 32'h04);

      // R5 interrupt gating
      push(3, 50);
      bus_write(A_MASK, 16'h0008);
      check("R5 irq off while disabled", 32'(irq), 32'd0);
      bus_write(A_CFG, 16'h0001);
      check("R5 irq on when enabled and unmasked", 32'(irq), 32'd1);
      bus_write(A_MASK, 16'h0010);
      check("R5 irq off when masked", 32'(irq), 32'd0);
      bus_write(A_MASK, 16'h0008);
      check("R5 irq back on", 32'(irq), 32'd1);
      read_check("R5 status source", A_STAT, 32'h08);
      check("R5 irq drops after status read", 32'(irq), 32'd0);
      bus_write(A_CFG, 16'h0000);

      // R6 fan periods (ticks every second cycle)
      read_check("R6 fan 0 period 40 cycles", A_FAN, 32'd20);
      read_check("R6 fan 1 period 100 cycles", 6'(A_FAN + 1), 32'd50);
      fan_per0 = 16;
      repeat (120) @(negedge clk);
      read_check("R6 fan 0 period 16 cycles", A_FAN, 32'd8);
      fan_per1 = 0;
      repeat (700) @(negedge clk);
      read_check("R6 stalled fan saturates", 6'(A_FAN + 1), 32'hFF);
      read_check("R6 running fan unaffected", A_FAN, 32'd8);

      // R7 intrusion latch
      intr_in = 1'b1;
      repeat (6) @(negedge clk);
      intr_in = 1'b0;
      repeat (6) @(negedge clk);
      read_check("R7 intrusion bit sticky", A_STAT, 32'h80);
      read_check("R7 intrusion bit cleared", A_STAT, 32'h00);

      // R8 clear pulse
      begin
         int base;
         base = low_cnt;
         bus_write(A_CFG, 16'h0002);
         repeat (12) @(negedge clk);
         check("R8 clear pulse length", 32'(low_cnt - base), 32'(CLR_PULSE));
      end
      read_check("R8 command bit reads zero", A_CFG, 32'd0);
      bus_write(A_CFG, 16'h0003);
      read_check("R8 enable kept, command reads zero", A_CFG, 32'd1);
      repeat (8) @(negedge clk);
      check("R8 pulse over", 32'(intr_clr_n), 32'd1);
      bus_write(A_CFG, 16'h0000);

      // R9 voltage-ID capture
      vid_in = 5'h15;
      repeat (4) @(negedge clk);
      read_check("R9 vid pattern 15", A_VID, 32'h15);
      vid_in = 5'h0A;
      repeat (4) @(negedge clk);
      read_check("R9 vid pattern 0A", A_VID, 32'h0A);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks + 1);
         $finish;
      end
   end

endmodule